// File: doc/BRIEF.md
# Indexed Interrupt Redirection Register File

This block is the bus-side register file of an interrupt redirection unit. Software does not address its registers directly. It first writes an index into a select register at one bus offset. It then reads or writes the chosen register through a data window at a second offset. The registers behind the window are:

- a unit identifier;
- a read-only version word that also reports how many interrupt pins the unit has;
- an arbitration word that always reads as zero;
- one 64-bit redirection entry per pin, reached as two 32-bit halves at neighbouring indices.

The complete redirection table is exported as a flat vector for the servicing logic. A one-cycle strobe tells that logic to rescan the table after any write to a table half. Read data is combinational: it is valid in the same cycle as the read request. Writes take effect at the clock edge that samples them.

Top module: `irq_regfile_top`

## Requirements
- R1: While `rst` is high and after it is released, the select index is 0 and the identifier is 0. Every table entry reads 64'h0000_0000_0001_0000, which means only the mask bit (bit 16) is set. `tbl_wr_pulse` is low.
- R2: Only `bus_addr[7:0]` is decoded; bits 11:8 are ignored.
  - Offset 0x00 is the select register. A write there stores `bus_wdata[7:0]` whatever the `bus_size` value. A read returns the stored index zero-extended to 32 bits.
  - Offset 0x10 is the data window.
- R3: `bus_size` gives the access width in bytes. A window access with `bus_size` other than 4 is ignored: a write changes nothing, and a read returns 0.
- R4: Index 0x00 is the identifier. A 4-byte window write keeps only `bus_wdata[27:24]`. A read returns those 4 bits at bits 27:24, with all other bits 0.
- R5: Index 0x01 reads as 0x11 ORed with (NUM_PINS-1) placed in bits 23:16. With 24 pins this is 32'h0017_0011. Writes to it have no effect.
- R6: Index 0x02 always reads 0 and ignores writes.
- R7: Index 0x10+2k reaches bits 31:0 of entry k, and index 0x11+2k reaches bits 63:32 of entry k. A write to one half leaves the other half unchanged. Entry k appears on `tbl_q[64k+63:64k]` from the cycle after the write.
- R8: Window reads of indices 0x03..0x0F, and of indices at or above 0x10+2*NUM_PINS, return 0. Window writes to those indices change no register.
- R9: `tbl_wr_pulse` is high for exactly the one cycle after each accepted table-half write. It stays low after every other write: select, identifier, version, arbitration, out-of-range index, or wrong size.
- R10: Accesses to any offset other than 0x00 and 0x10 read 0 and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address within the 4 KB region |
| bus_rd | input | 1 | Read request; `bus_rdata` is valid in the same cycle |
| bus_wr | input | 1 | Write request, taken at the rising clock edge |
| bus_size | input | 3 | Access width in bytes (1, 2 or 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when no read is requested |
| tbl_q | output | NUM_PINS*64 | Flattened redirection table, entry k at bits 64k+63:64k |
| tbl_wr_pulse | output | 1 | One-cycle strobe after a table-half write |

## Verification
The scoreboard drives the window in four ways:

- **Indices.** Every kind of index is tried: identifier, version, arbitration, the low and high halves of the first and last entries, the unused gap below the table base, and indices past the table end. This shows that the decode distinguishes the register kinds and keeps the table bounds.
- **Halves.** Each half of an entry is rewritten while the exported table is checked. This separates a correct half-merge from a whole-entry overwrite.
- **Access width and aliasing.** Window accesses use 1-, 2- and 4-byte sizes, and the same offsets are also reached through aliased upper address bits. These patterns tell the size gate apart from the offset decode.
- **Strobe.** The strobe is sampled after every kind of write, so a strobe that fires on non-table writes is caught.

// File: rtl/irq_regfile_pkg.sv
`timescale 1ns/1ps
package irq_regfile_pkg;

    localparam int BUS_AW   = 12;
    localparam int BUS_DW   = 32;
    localparam int SEL_W    = 8;
    localparam int OFS_W    = 8;
    localparam int ENT_W    = 64;
    localparam int HALF_W   = ENT_W / 2;
    localparam int SIZE_W   = 3;

    // Bus offsets (low address byte)
    localparam logic [OFS_W-1:0] OFS_SEL = 8'h00;
    localparam logic [OFS_W-1:0] OFS_WIN = 8'h10;

    // Window indices
    localparam logic [SEL_W-1:0] IDX_ID  = 8'h00;
    localparam logic [SEL_W-1:0] IDX_VER = 8'h01;
    localparam logic [SEL_W-1:0] IDX_ARB = 8'h02;
    localparam logic [SEL_W-1:0] IDX_TBL = 8'h10;

    localparam logic [SIZE_W-1:0] WIN_SIZE = 3'd4;

    // Field layout
    localparam int ID_LSB   = 24;
    localparam int ID_W     = 4;
    localparam int CNT_LSB  = 16;
    localparam int MASK_BIT = 16;
    localparam logic [7:0] VER_CODE = 8'h11;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_SEL,
        TGT_ID,
        TGT_VER,
        TGT_ARB,
        TGT_TBL
    } tgt_e;

    typedef struct packed {
        tgt_e             tgt;
        logic             size_ok;
        logic             hi_half;
        logic [SEL_W-1:0] ent;
    } acc_s;

    function automatic logic [BUS_DW-1:0] ver_word(input int pins);
        logic [7:0] cnt;
        cnt = 8'(pins - 1);
        return BUS_DW'(VER_CODE) | (BUS_DW'(cnt) << CNT_LSB);
    endfunction

    function automatic logic [ENT_W-1:0] ent_reset();
        return ENT_W'(1) << MASK_BIT;
    endfunction

endpackage

// File: rtl/irq_regfile_decode.sv
`timescale 1ns/1ps
module irq_regfile_decode
    import irq_regfile_pkg::*;
#(
    parameter int NUM_PINS = 24
) (
    input  logic [OFS_W-1:0]  off,
    input  logic [SIZE_W-1:0] size,
    input  logic [SEL_W-1:0]  sel_q,
    output acc_s              acc
);

    logic [SEL_W-1:0] rel;
    logic [SEL_W-1:0] ent_idx;

    assign rel     = sel_q - IDX_TBL;
    assign ent_idx = {1'b0, rel[SEL_W-1:1]};

    always_comb begin
        acc         = '0;
        acc.tgt     = TGT_NONE;
        acc.size_ok = (size == WIN_SIZE);
        acc.hi_half = rel[0];
        acc.ent     = ent_idx;
        if (off == OFS_SEL) begin
            acc.tgt = TGT_SEL;
        end else if (off == OFS_WIN) begin
            if (sel_q == IDX_ID) begin
                acc.tgt = TGT_ID;
            end else if (sel_q == IDX_VER) begin
                acc.tgt = TGT_VER;
            end else if (sel_q == IDX_ARB) begin
                acc.tgt = TGT_ARB;
            end else if (sel_q >= IDX_TBL && int'(ent_idx) < NUM_PINS) begin
                acc.tgt = TGT_TBL;
            end
        end
    end

endmodule

// File: rtl/irq_redir_table.sv
`timescale 1ns/1ps
module irq_redir_table
    import irq_regfile_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int EW       = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic                      wr_hi,
    input  logic [EW-1:0]             wr_ent,
    input  logic [HALF_W-1:0]         wr_data,
    input  logic                      rd_hi,
    input  logic [EW-1:0]             rd_ent,
    output logic [HALF_W-1:0]         rd_word,
    output logic [NUM_PINS*ENT_W-1:0] table_flat
);

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_ent
        logic [ENT_W-1:0] ent_q;
        logic             hit;

        assign hit = wr_en && (wr_ent == EW'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q <= ent_reset();
            end else if (hit) begin
                if (wr_hi) begin
                    ent_q[ENT_W-1:HALF_W] <= wr_data;
                end else begin
                    ent_q[HALF_W-1:0] <= wr_data;
                end
            end
        end

        assign table_flat[g*ENT_W +: ENT_W] = ent_q;
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (rd_ent == EW'(i)) begin
                rd_word = rd_hi ? table_flat[i*ENT_W + HALF_W +: HALF_W]
                                : table_flat[i*ENT_W +: HALF_W];
            end
        end
    end

endmodule

// File: rtl/irq_regfile_top.sv
`timescale 1ns/1ps
module irq_regfile_top
    import irq_regfile_pkg::*;
#(
    parameter int NUM_PINS = 24
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [BUS_AW-1:0]         bus_addr,
    input  logic                      bus_rd,
    input  logic                      bus_wr,
    input  logic [SIZE_W-1:0]         bus_size,
    input  logic [BUS_DW-1:0]         bus_wdata,
    output logic [BUS_DW-1:0]         bus_rdata,
    output logic [NUM_PINS*ENT_W-1:0] tbl_q,
    output logic                      tbl_wr_pulse
);

    localparam int EW = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    logic [SEL_W-1:0]  sel_q;
    logic [ID_W-1:0]   id_q;
    logic              strobe_q;
    acc_s              acc;
    logic              tbl_we;
    logic [HALF_W-1:0] tbl_rd_word;
    logic              unused_addr_hi;
    logic              unused_ent_hi;

    assign unused_addr_hi = ^bus_addr[BUS_AW-1:OFS_W];
    assign unused_ent_hi  = ^acc.ent[SEL_W-1:EW];

    irq_regfile_decode #(.NUM_PINS(NUM_PINS)) dec_i (
        .off   (bus_addr[OFS_W-1:0]),
        .size  (bus_size),
        .sel_q (sel_q),
        .acc   (acc)
    );

    assign tbl_we = bus_wr && acc.size_ok && (acc.tgt == TGT_TBL);

    irq_redir_table #(.NUM_PINS(NUM_PINS), .EW(EW)) tbl_i (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (tbl_we),
        .wr_hi      (acc.hi_half),
        .wr_ent     (acc.ent[EW-1:0]),
        .wr_data    (bus_wdata),
        .rd_hi      (acc.hi_half),
        .rd_ent     (acc.ent[EW-1:0]),
        .rd_word    (tbl_rd_word),
        .table_flat (tbl_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q    <= '0;
            id_q     <= '0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= tbl_we;
            if (bus_wr && acc.tgt == TGT_SEL) begin
                sel_q <= bus_wdata[SEL_W-1:0];
            end
            if (bus_wr && acc.size_ok && acc.tgt == TGT_ID) begin
                id_q <= bus_wdata[ID_LSB +: ID_W];
            end
        end
    end

    assign tbl_wr_pulse = strobe_q;

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (acc.tgt)
                TGT_SEL: bus_rdata = BUS_DW'(sel_q);
                TGT_ID:  if (acc.size_ok) bus_rdata = BUS_DW'(id_q) << ID_LSB;
                TGT_VER: if (acc.size_ok) bus_rdata = ver_word(NUM_PINS);
                TGT_TBL: if (acc.size_ok) bus_rdata = tbl_rd_word;
                default: bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/irq_regfile_chk.sv
`timescale 1ns/1ps
module irq_regfile_chk
    import irq_regfile_pkg::*;
#(
    parameter int NUM_PINS = 24
) (
    input logic                      clk,
    input logic                      rst,
    input logic [OFS_W-1:0]          bus_off,
    input logic                      bus_rd,
    input logic                      bus_wr,
    input logic [SIZE_W-1:0]         bus_size,
    input logic [BUS_DW-1:0]         bus_rdata,
    input logic [NUM_PINS*ENT_W-1:0] tbl_q,
    input logic                      tbl_wr_pulse,
    input logic [SEL_W-1:0]          sel_q
);

    // R9
    strobe_after_win_write_chk: assert property (@(posedge clk) disable iff (rst)
        tbl_wr_pulse |-> $past(bus_wr && bus_size == WIN_SIZE && bus_off == OFS_WIN));

    // R7
    table_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tbl_wr_pulse |-> $stable(tbl_q));

    // R3
    bad_size_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_off == OFS_WIN && bus_size != WIN_SIZE) |-> bus_rdata == '0);

    // R5
    version_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_off == OFS_WIN && bus_size == WIN_SIZE && sel_q == IDX_VER)
            |-> bus_rdata == ver_word(NUM_PINS));

    // R6
    arb_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_off == OFS_WIN && sel_q == IDX_ARB) |-> bus_rdata == '0);

    // R10
    undecoded_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_off != OFS_WIN && bus_off != OFS_SEL) |-> bus_rdata == '0);

endmodule

bind irq_regfile_top irq_regfile_chk #(.NUM_PINS(NUM_PINS)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .bus_off      (bus_addr[7:0]),
    .bus_rd       (bus_rd),
    .bus_wr       (bus_wr),
    .bus_size     (bus_size),
    .bus_rdata    (bus_rdata),
    .tbl_q        (tbl_q),
    .tbl_wr_pulse (tbl_wr_pulse),
    .sel_q        (sel_q)
);

// File: tb/irq_regfile_top_tb_top.sv
`timescale 1ns/1ps
module irq_regfile_top_tb_top;

    localparam int NP = 24;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [11:0]    bus_addr = '0;
    logic           bus_rd = 1'b0;
    logic           bus_wr = 1'b0;
    logic [2:0]     bus_size = 3'd4;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic [NP*64-1:0] tbl_q;
    logic           tbl_wr_pulse;

    always #2.5 clk = ~clk;

    irq_regfile_top #(.NUM_PINS(NP)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .bus_addr     (bus_addr),
        .bus_rd       (bus_rd),
        .bus_wr       (bus_wr),
        .bus_size     (bus_size),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .tbl_q        (tbl_q),
        .tbl_wr_pulse (tbl_wr_pulse)
    );

    typedef struct {
        logic [31:0] data;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Monitor: pops the expected read data in the cycle of each read
    always @(negedge clk) begin
        exp_t e;
        if (bus_rd) begin
            if (exp_q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL monitor act=%h exp=none", bus_rdata);
            end else begin
                e = exp_q.pop_front();
                chk(e.req, {32'h0, bus_rdata}, {32'h0, e.data});
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [2:0] sz);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_size = sz; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [2:0] sz,
                      input logic [31:0] exp, input string req);
        @(posedge clk); #1;
        bus_addr = a; bus_size = sz; bus_rd = 1'b1;
        exp_q.push_back('{exp, req});
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic sel(input logic [7:0] idx);
        wr(12'h000, {24'h0, idx}, 3'd4);
    endtask

    function automatic logic [63:0] ent(input int k);
        return tbl_q[k*64 +: 64];
    endfunction

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog act=hung exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        chk("R1 strobe", {63'h0, tbl_wr_pulse}, 64'h0);
        chk("R1 entry0", ent(0), 64'h0000_0000_0001_0000);
        chk("R1 entry23", ent(23), 64'h0000_0000_0001_0000);
        rd(12'h000, 3'd4, 32'h0, "R1 select");
        rd(12'h010, 3'd4, 32'h0, "R1 id");
        rd(12'h010 + 12'h0, 3'd4, 32'h0, "R1 id again");
        sel(8'h10);
        rd(12'h010, 3'd4, 32'h0001_0000, "R1 entry0 low");

        // R2 select register, size-free, aliased upper address bits
        wr(12'h000, 32'h0000_0012, 3'd1);
        chk("R2 no strobe", {63'h0, tbl_wr_pulse}, 64'h0);
        rd(12'h000, 3'd1, 32'h12, "R2 readback");
        wr(12'h700, 32'hABCD_0034, 3'd4);
        rd(12'hF00, 3'd4, 32'h34, "R2 alias and 8-bit");

        // R4 identifier field
        sel(8'h00);
        wr(12'h010, 32'hFFFF_FFFF, 3'd4);
        chk("R9 id write no strobe", {63'h0, tbl_wr_pulse}, 64'h0);
        rd(12'h010, 3'd4, 32'h0F00_0000, "R4 id masked");
        wr(12'h310, 32'h05A5_A5A5, 3'd4);
        rd(12'h510, 3'd4, 32'h0500_0000, "R4 id via alias");

        // R5 version
        sel(8'h01);
        rd(12'h010, 3'd4, 32'h0017_0011, "R5 version");
        wr(12'h010, 32'h0, 3'd4);
        rd(12'h010, 3'd4, 32'h0017_0011, "R5 version after write");

        // R6 arbitration
        sel(8'h02);
        wr(12'h010, 32'hFFFF_FFFF, 3'd4);
        rd(12'h010, 3'd4, 32'h0, "R6 arb");

        // R7 entry halves, R9 strobe timing
        sel(8'h16);
        wr(12'h010, 32'hA5A5_0033, 3'd4);
        chk("R9 strobe high", {63'h0, tbl_wr_pulse}, 64'h1);
        @(posedge clk); #1;
        chk("R9 strobe one cycle", {63'h0, tbl_wr_pulse}, 64'h0);
        chk("R7 entry3 low", ent(3), 64'h0000_0000_A5A5_0033);
        sel(8'h17);
        wr(12'h010, 32'h5A00_0000, 3'd4);
        chk("R7 entry3 both", ent(3), 64'h5A00_0000_A5A5_0033);
        rd(12'h010, 3'd4, 32'h5A00_0000, "R7 read high");
        sel(8'h16);
        rd(12'h010, 3'd4, 32'hA5A5_0033, "R7 read low");
        wr(12'h010, 32'h0000_0044, 3'd4);
        chk("R7 high kept", ent(3), 64'h5A00_0000_0000_0044);
        sel(8'h3F);
        wr(12'h010, 32'hFF00_0000, 3'd4);
        chk("R7 last entry high", ent(23), 64'hFF00_0000_0001_0000);
        chk("R7 neighbour untouched", ent(22), 64'h0000_0000_0001_0000);

        // R8 out-of-range indices
        sel(8'h40);
        wr(12'h010, 32'hDEAD_BEEF, 3'd4);
        chk("R8 no strobe", {63'h0, tbl_wr_pulse}, 64'h0);
        rd(12'h010, 3'd4, 32'h0, "R8 past end read");
        chk("R8 entry23 kept", ent(23), 64'hFF00_0000_0001_0000);
        chk("R8 entry0 kept", ent(0), 64'h0000_0000_0001_0000);
        sel(8'h05);
        wr(12'h010, 32'hFFFF_FFFF, 3'd4);
        rd(12'h010, 3'd4, 32'h0, "R8 gap read");
        sel(8'h0F);
        rd(12'h010, 3'd4, 32'h0, "R8 gap top read");
        sel(8'h00);
        rd(12'h010, 3'd4, 32'h0500_0000, "R8 id kept");

        // R3 wrong access width
        sel(8'h16);
        wr(12'h010, 32'h1111_1111, 3'd2);
        chk("R3 no strobe", {63'h0, tbl_wr_pulse}, 64'h0);
        chk("R3 entry kept", ent(3), 64'h5A00_0000_0000_0044);
        rd(12'h010, 3'd2, 32'h0, "R3 half read");
        rd(12'h010, 3'd1, 32'h0, "R3 byte read");
        rd(12'h010, 3'd4, 32'h0000_0044, "R3 word read");

        // R10 undecoded offsets
        rd(12'h020, 3'd4, 32'h0, "R10 offset 0x20");
        wr(12'h014, 32'h7777_7777, 3'd4);
        chk("R10 no strobe", {63'h0, tbl_wr_pulse}, 64'h0);
        chk("R10 entry kept", ent(3), 64'h5A00_0000_0000_0044);
        rd(12'h000, 3'd4, 32'h16, "R10 select kept");

        repeat (3) @(posedge clk);
        #1;
        chk("scoreboard drained", 64'(exp_q.size()), 64'h0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule